// File: doc/BRIEF.md
# Guarded Mirrored Stable-Store Controller

This block fronts a small non-volatile word store that is held as two mirrored copies. A host reaches it over one 16-bit multiplexed bus. An address phase opens a transfer. Each data phase after it uses the next word address. Every bus phase carries an odd parity bit, and a phase with bad parity has no effect. Runaway software cannot overwrite a word by accident: before any write, the caller must first present the value that the word holds now.

A transfer is either a single-word transfer or a block. In single-word mode each new word needs its own guard phase. In block mode only the word at the start address is guarded, and the words that follow land at consecutive addresses. The host ends a block by sending a trailing checksum word chosen so that all data words of the block, checksum included, sum to zero modulo 2^16. A block cut short therefore reads back as uncommitted. Both copies are written in the same cycle. Reads of both copies compare them, and a block read reports which copy holds a self-consistent block. Either copy can be chosen alone, both for repair writes and for inspection reads.

The address width is a parameter. The full-size store is 14 bits (16K words), and the default is 10 bits so that the behavioural arrays stay small.

Top module: `guarded_store`

## Requirements
- R1: After reset, reject, par_err, mism_err, commit_ok, commit_bad and rd_valid are 0, and sum_ok is 2'b00.
- R2: A phase is valid only when bus_ad together with bus_par has odd parity (an odd count of ones). A strobe phase with bad parity changes no state, raises par_err, and leaves par_err set until the next valid address phase, which clears it.
- R3: On a valid address strobe, bus_ad[ADDR_W-1:0] becomes the word address and blk_mode and copy_sel are captured. copy_sel 2'b01 selects copy A only, 2'b10 selects copy B only, and 2'b00 or 2'b11 selects both. The first write phase after the address phase is a guard. It succeeds only if its value equals the current contents of every selected copy at the current address. Otherwise reject rises and memory is unchanged.
- R4: Once reject is set, every further write phase is ignored until the next valid address strobe, which clears reject.
- R5: In single mode, a write phase that follows a successful guard stores the word and advances the address by one. The write phase after that is again a guard, for the new address.
- R6: In block mode, only the first word is guarded. Every later write phase stores its word and advances the address.
- R7: A block write phase with blk_end high ends the transfer. On the cycle after it, commit_ok pulses if the 16-bit sum of all data words of the block, that final word included, is zero. Otherwise commit_bad pulses.
- R8: With both copies selected, a data write stores the word to both copies in the same cycle. With one copy selected, only that copy changes.
- R9: A read phase in an open transfer returns, on the next cycle, the word at the current address with rd_valid high and rd_par giving odd parity. The word comes from copy B when copy_sel is 2'b10 and from copy A otherwise. The address then advances by one.
- R10: A read with both copies selected whose two copies differ sets mism_err, which stays set until reset.
- R11: A block read phase with blk_end high ends the transfer. On the next cycle, sum_ok[0] and sum_ok[1] show whether the 16-bit sum of the words read from copy A and from copy B, respectively, is zero.
- R12: The word address wraps from the top word to word 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_ad | input | 16 | Multiplexed address or data word |
| bus_par | input | 1 | Odd parity bit for bus_ad |
| addr_stb | input | 1 | Address phase strobe |
| wr_stb | input | 1 | Write phase strobe (guard or data) |
| rd_stb | input | 1 | Read phase strobe |
| blk_mode | input | 1 | Block transfer, captured at the address phase |
| copy_sel | input | 2 | Copy selection, captured at the address phase |
| blk_end | input | 1 | Marks the final phase of a block |
| rd_data | output | 16 | Read word |
| rd_par | output | 1 | Odd parity bit for rd_data |
| rd_valid | output | 1 | rd_data is new this cycle |
| reject | output | 1 | Guard failed in this transfer |
| par_err | output | 1 | A phase with bad parity was seen in this transfer |
| mism_err | output | 1 | Sticky flag for a copy mismatch on a read |
| commit_ok | output | 1 | Block closed with a zero sum |
| commit_bad | output | 1 | Block closed with a nonzero sum |
| sum_ok | output | 2 | Per-copy zero-sum result of the last block read |

## Verification
A wrong stored address or a slipped increment shows up one cycle after the next read phase, as a word that differs from the one written there. Running over all addresses of a small store, wrap included, exposes such faults everywhere. A stuck or mis-set transfer state shows at the ports within one phase. It appears as a guard that should have failed but was accepted, or the reverse, and reading the target word after each write attempt confirms the effect. A faulty checksum accumulator, or a write path that reaches only one copy, is visible on the cycle after the block's final phase, through commit_ok, commit_bad, sum_ok or mism_err.

// File: rtl/gs_pkg.sv
package gs_pkg;
    localparam int WORD_W = 16;
    localparam int COPIES = 2;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_GUARD,
        ST_DATA,
        ST_REJECT
    } gs_state_e;

    typedef struct packed {
        logic blk;
        logic use_a;
        logic use_b;
    } gs_xfer_t;

    typedef struct packed {
        logic is_addr;
        logic is_wr;
        logic is_rd;
        logic bad;
    } gs_phase_t;

    function automatic logic odd_ok(input logic [WORD_W-1:0] d, input logic p);
        return ^{d, p};
    endfunction

    function automatic logic odd_gen(input logic [WORD_W-1:0] d);
        return ~^d;
    endfunction

    function automatic gs_xfer_t decode_sel(input logic blk, input logic [1:0] sel);
        gs_xfer_t x;
        x.blk   = blk;
        x.use_a = (sel != 2'b10);
        x.use_b = (sel != 2'b01);
        return x;
    endfunction
endpackage

// File: rtl/gs_phase.sv
module gs_phase
    import gs_pkg::*;
(
    input  logic [WORD_W-1:0] bus_ad,
    input  logic              bus_par,
    input  logic              addr_stb,
    input  logic              wr_stb,
    input  logic              rd_stb,
    output gs_phase_t         ph
);
    logic good;
    logic any;

    always_comb begin
        good       = odd_ok(bus_ad, bus_par);
        any        = addr_stb | wr_stb | rd_stb;
        ph.bad     = any & ~good;
        ph.is_addr = good & addr_stb;
        ph.is_wr   = good & ~addr_stb & wr_stb;
        ph.is_rd   = good & ~addr_stb & ~wr_stb & rd_stb;
    end
endmodule

// File: rtl/gs_mirror.sv
module gs_mirror
    import gs_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input  logic                           clk,
    input  logic [ADDR_W-1:0]              addr,
    input  logic [WORD_W-1:0]              wdata,
    input  logic [COPIES-1:0]              we,
    output logic [COPIES-1:0][WORD_W-1:0]  rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    for (genvar c = 0; c < COPIES; c++) begin : g_copy
        logic [WORD_W-1:0] mem [DEPTH];

        initial begin
            for (int i = 0; i < DEPTH; i++) mem[i] = '0;
        end

        always_ff @(posedge clk) begin
            if (we[c]) mem[addr] <= wdata;
        end

        assign rdata[c] = mem[addr];
    end
endmodule

// File: rtl/gs_sum.sv
module gs_sum
    import gs_pkg::*;
#(
    parameter int LANES = 2
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          clr,
    input  logic [LANES-1:0]              add,
    input  logic [LANES-1:0][WORD_W-1:0]  val,
    output logic [LANES-1:0][WORD_W-1:0]  sum
);
    for (genvar l = 0; l < LANES; l++) begin : g_lane
        always_ff @(posedge clk) begin
            if (rst || clr)  sum[l] <= '0;
            else if (add[l]) sum[l] <= sum[l] + val[l];
        end
    end
endmodule

// File: rtl/guarded_store.sv
module guarded_store
    import gs_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [15:0] bus_ad,
    input  logic        bus_par,
    input  logic        addr_stb,
    input  logic        wr_stb,
    input  logic        rd_stb,
    input  logic        blk_mode,
    input  logic [1:0]  copy_sel,
    input  logic        blk_end,
    output logic [15:0] rd_data,
    output logic        rd_par,
    output logic        rd_valid,
    output logic        reject,
    output logic        par_err,
    output logic        mism_err,
    output logic        commit_ok,
    output logic        commit_bad,
    output logic [1:0]  sum_ok
);
    gs_phase_t                        ph;
    gs_state_e                        st_q;
    gs_xfer_t                         xf_q;
    logic [ADDR_W-1:0]                addr_q;
    logic [COPIES-1:0][WORD_W-1:0]    cur;
    logic [COPIES-1:0]                we;
    logic [0:0][WORD_W-1:0]           wsum;
    logic [COPIES-1:0][WORD_W-1:0]    rsum;
    logic                             guard_ok;
    logic                             wr_data_ph;
    logic                             rd_ok;
    logic [WORD_W-1:0]                rd_pick;
    logic [WORD_W-1:0]                wtotal;

    gs_phase u_phase (
        .bus_ad  (bus_ad),
        .bus_par (bus_par),
        .addr_stb(addr_stb),
        .wr_stb  (wr_stb),
        .rd_stb  (rd_stb),
        .ph      (ph)
    );

    always_comb begin
        guard_ok   = (!xf_q.use_a || bus_ad == cur[0]) &&
                     (!xf_q.use_b || bus_ad == cur[1]);
        wr_data_ph = ph.is_wr && (st_q == ST_DATA);
        we         = {xf_q.use_b, xf_q.use_a} & {COPIES{wr_data_ph}};
        rd_ok      = ph.is_rd && (st_q != ST_IDLE);
        rd_pick    = xf_q.use_a ? cur[0] : cur[1];
        wtotal     = wsum[0] + bus_ad;
    end

    gs_mirror #(.ADDR_W(ADDR_W)) u_mirror (
        .clk  (clk),
        .addr (addr_q),
        .wdata(bus_ad),
        .we   (we),
        .rdata(cur)
    );

    gs_sum #(.LANES(1)) u_wsum (
        .clk(clk),
        .rst(rst),
        .clr(ph.is_addr),
        .add(wr_data_ph && xf_q.blk),
        .val(bus_ad),
        .sum(wsum)
    );

    gs_sum #(.LANES(COPIES)) u_rsum (
        .clk(clk),
        .rst(rst),
        .clr(ph.is_addr),
        .add({COPIES{rd_ok && xf_q.blk}}),
        .val(cur),
        .sum(rsum)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q       <= ST_IDLE;
            xf_q       <= '0;
            addr_q     <= '0;
            rd_data    <= '0;
            rd_par     <= 1'b1;
            rd_valid   <= 1'b0;
            reject     <= 1'b0;
            par_err    <= 1'b0;
            mism_err   <= 1'b0;
            commit_ok  <= 1'b0;
            commit_bad <= 1'b0;
            sum_ok     <= 2'b00;
        end else begin
            rd_valid   <= 1'b0;
            commit_ok  <= 1'b0;
            commit_bad <= 1'b0;
            if (ph.bad) par_err <= 1'b1;

            if (ph.is_addr) begin
                addr_q  <= bus_ad[ADDR_W-1:0];
                xf_q    <= decode_sel(blk_mode, copy_sel);
                st_q    <= ST_GUARD;
                reject  <= 1'b0;
                par_err <= 1'b0;
            end else if (ph.is_wr) begin
                unique case (st_q)
                    ST_GUARD: begin
                        st_q   <= guard_ok ? ST_DATA : ST_REJECT;
                        reject <= !guard_ok;
                    end
                    ST_DATA: begin
                        addr_q <= addr_q + 1'b1;
                        if (!xf_q.blk) begin
                            st_q <= ST_GUARD;
                        end else if (blk_end) begin
                            st_q       <= ST_IDLE;
                            commit_ok  <= (wtotal == '0);
                            commit_bad <= (wtotal != '0);
                        end
                    end
                    default: ;
                endcase
            end else if (rd_ok) begin
                rd_data  <= rd_pick;
                rd_par   <= odd_gen(rd_pick);
                rd_valid <= 1'b1;
                addr_q   <= addr_q + 1'b1;
                if (xf_q.use_a && xf_q.use_b && cur[0] != cur[1]) mism_err <= 1'b1;
                if (xf_q.blk && blk_end) begin
                    st_q   <= ST_IDLE;
                    sum_ok <= {(rsum[1] + cur[1]) == '0, (rsum[0] + cur[0]) == '0};
                end
            end
        end
    end
endmodule

// File: rtl/gs_checker.sv
module gs_checker (
    input logic        clk,
    input logic        rst,
    input logic [15:0] bus_ad,
    input logic        bus_par,
    input logic        addr_stb,
    input logic        wr_stb,
    input logic        rd_stb,
    input logic        blk_end,
    input logic        rd_valid,
    input logic        reject,
    input logic        par_err,
    input logic        mism_err,
    input logic        commit_ok,
    input logic        commit_bad
);
    // R1
    reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !reject && !par_err && !mism_err && !rd_valid && !commit_ok && !commit_bad);

    // R2
    par_source_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(par_err) |-> $past(addr_stb || wr_stb || rd_stb) && !(^{$past(bus_ad), $past(bus_par)}));

    // R4
    reject_hold_chk: assert property (@(posedge clk) disable iff (rst)
        reject && !addr_stb |=> reject);

    // R7
    commit_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(commit_ok && commit_bad));

    // R7
    commit_src_chk: assert property (@(posedge clk) disable iff (rst)
        (commit_ok || commit_bad) |-> $past(wr_stb && blk_end));

    // R9
    rd_src_chk: assert property (@(posedge clk) disable iff (rst)
        rd_valid |-> $past(rd_stb));

    // R10
    mism_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        mism_err |=> mism_err);
endmodule

bind guarded_store gs_checker u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_ad    (bus_ad),
    .bus_par   (bus_par),
    .addr_stb  (addr_stb),
    .wr_stb    (wr_stb),
    .rd_stb    (rd_stb),
    .blk_end   (blk_end),
    .rd_valid  (rd_valid),
    .reject    (reject),
    .par_err   (par_err),
    .mism_err  (mism_err),
    .commit_ok (commit_ok),
    .commit_bad(commit_bad)
);

// File: tb/sim_guarded_store.sv
`timescale 1ns/1ps
module sim_guarded_store;
    localparam int AW = 4;
    localparam int N  = 1 << AW;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] bus_ad = '0;
    logic        bus_par = 1'b1;
    logic        addr_stb = 1'b0, wr_stb = 1'b0, rd_stb = 1'b0;
    logic        blk_mode = 1'b0, blk_end = 1'b0;
    logic [1:0]  copy_sel = 2'b11;
    logic [15:0] rd_data;
    logic        rd_par, rd_valid, reject, par_err, mism_err, commit_ok, commit_bad;
    logic [1:0]  sum_ok;

    int n_chk = 0, n_err = 0;
    logic [15:0] ma [N];
    logic [15:0] mb [N];

    always #2 clk = ~clk;

    guarded_store #(.ADDR_W(AW)) u0 (.*);

    function automatic logic [15:0] fa(input int a);
        return 16'hA5C3 ^ 16'(a * 16'h0911);
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic phase(input int kind, input logic [15:0] d, input logic e, input logic badp);
        @(negedge clk);
        bus_ad   = d;
        bus_par  = badp ? ^d : ~^d;
        blk_end  = e;
        addr_stb = (kind == 0);
        wr_stb   = (kind == 1);
        rd_stb   = (kind == 2);
        @(negedge clk);
        addr_stb = 1'b0; wr_stb = 1'b0; rd_stb = 1'b0; blk_end = 1'b0;
    endtask

    task automatic do_addr(input int a, input logic blk, input logic [1:0] sel);
        blk_mode = blk; copy_sel = sel;
        phase(0, 16'(a), 1'b0, 1'b0);
    endtask

    task automatic do_wr(input logic [15:0] d, input logic e);
        phase(1, d, e, 1'b0);
    endtask

    task automatic do_rd(input string tag, input logic e, input logic [15:0] exp);
        phase(2, 16'h0001, e, 1'b0);
        chk({tag, " data"}, rd_data, exp);
        chk({tag, " valid/parity"}, {rd_valid, ^{rd_data, rd_par}}, 2'b11);
    endtask

    initial begin
        #(4 * 200000);
        n_err++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        logic [15:0] s, cs;
        for (int i = 0; i < N; i++) begin ma[i] = '0; mb[i] = '0; end
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk("R1 flags", {reject, par_err, mism_err, commit_ok, commit_bad, rd_valid, sum_ok},
            8'h00);

        // R3 R5 R8: guarded single writes to every address
        for (int a = 0; a < N; a++) begin
            do_addr(a, 1'b0, 2'b11);
            do_wr(ma[a], 1'b0);
            do_wr(fa(a), 1'b0);
            chk("R3 guard accepted", reject, 1'b0);
            ma[a] = fa(a); mb[a] = fa(a);
        end
        // R9 R12: sweep read with wrap
        do_addr(0, 1'b0, 2'b11);
        for (int a = 0; a <= N; a++) do_rd("R9 R12 sweep", 1'b0, ma[a % N]);
        chk("R10 no mismatch", mism_err, 1'b0);
        do_addr(0, 1'b0, 2'b10);
        for (int a = 0; a < N; a++) do_rd("R8 copy B sweep", 1'b0, mb[a]);

        // R3 wrong guard
        do_addr(7, 1'b0, 2'b11);
        do_wr(ma[7] + 16'd1, 1'b0);
        chk("R3 wrong guard rejected", reject, 1'b1);
        do_wr(16'h1234, 1'b0);
        do_rd("R3 word unchanged", 1'b0, ma[7]);

        // R5: second data without a new guard is a guard for next address
        do_addr(3, 1'b0, 2'b11);
        do_wr(ma[3], 1'b0);
        do_wr(16'h1111, 1'b0);
        ma[3] = 16'h1111; mb[3] = 16'h1111;
        chk("R5 first write ok", reject, 1'b0);
        do_wr(ma[4] ^ 16'h0001, 1'b0);
        chk("R5 second word needs guard", reject, 1'b1);
        // R4: later writes ignored even with correct guard
        do_wr(ma[4], 1'b0);
        do_wr(16'hAAAA, 1'b0);
        chk("R4 reject held", reject, 1'b1);
        do_addr(3, 1'b0, 2'b11);
        chk("R4 reject cleared by address", reject, 1'b0);
        do_rd("R5 stored", 1'b0, 16'h1111);
        do_rd("R4 ignored write", 1'b0, ma[4]);

        // R6 R7 R12: good block across the wrap point
        do_addr(14, 1'b1, 2'b11);
        do_wr(ma[14], 1'b0);
        s = 16'h0;
        for (int k = 0; k < 3; k++) begin
            logic [15:0] d;
            d = 16'h3C00 + 16'(k * 16'h0135);
            do_wr(d, 1'b0);
            chk("R7 no early commit", {commit_ok, commit_bad}, 2'b00);
            ma[(14 + k) % N] = d; mb[(14 + k) % N] = d;
            s = s + d;
        end
        cs = -s;
        do_wr(cs, 1'b1);
        ma[1] = cs; mb[1] = cs;
        chk("R7 good block commits", {commit_ok, commit_bad}, 2'b10);
        @(negedge clk);
        chk("R7 commit is a pulse", {commit_ok, commit_bad}, 2'b00);
        do_addr(14, 1'b1, 2'b11);
        for (int k = 0; k < 4; k++) do_rd("R6 R12 block readback", k == 3, ma[(14 + k) % N]);
        chk("R11 both copies sum to zero", sum_ok, 2'b11);

        // R7 bad checksum
        do_addr(8, 1'b1, 2'b11);
        do_wr(ma[8], 1'b0);
        do_wr(16'd5, 1'b0); do_wr(16'd6, 1'b0); do_wr(16'd7, 1'b1);
        ma[8] = 5; ma[9] = 6; ma[10] = 7; mb[8] = 5; mb[9] = 6; mb[10] = 7;
        chk("R7 bad block flagged", {commit_ok, commit_bad}, 2'b01);

        // R6 block guard only first word; failed guard blocks all words
        do_addr(11, 1'b1, 2'b11);
        do_wr(ma[11] ^ 16'h8000, 1'b0);
        do_wr(16'h4444, 1'b0); do_wr(16'h5555, 1'b1);
        chk("R6 block guard rejected", {reject, commit_ok, commit_bad}, 3'b100);
        do_addr(11, 1'b0, 2'b11);
        do_rd("R6 rejected block word", 1'b0, ma[11]);

        // R8 copy-only write, R10 mismatch
        do_addr(5, 1'b0, 2'b01);
        do_wr(ma[5], 1'b0);
        do_wr(16'hBEEF, 1'b0);
        ma[5] = 16'hBEEF;
        do_addr(5, 1'b0, 2'b10);
        do_rd("R8 copy B untouched", 1'b0, mb[5]);
        chk("R10 single copy read no compare", mism_err, 1'b0);
        do_addr(5, 1'b0, 2'b11);
        do_wr(16'hBEEF, 1'b0);
        chk("R3 guard must match both copies", reject, 1'b1);
        do_addr(5, 1'b0, 2'b11);
        do_rd("R9 both reads copy A", 1'b0, 16'hBEEF);
        chk("R10 mismatch set", mism_err, 1'b1);
        do_addr(0, 1'b0, 2'b11);
        do_rd("R10 matching read", 1'b0, ma[0]);
        chk("R10 mismatch sticky", mism_err, 1'b1);

        // R11 corrupt copy B inside committed block
        do_addr(15, 1'b0, 2'b10);
        do_wr(mb[15], 1'b0);
        do_wr(mb[15] ^ 16'h0040, 1'b0);
        mb[15] = mb[15] ^ 16'h0040;
        do_addr(14, 1'b1, 2'b11);
        for (int k = 0; k < 4; k++) do_rd("R11 block read", k == 3, ma[(14 + k) % N]);
        chk("R11 only copy A valid", sum_ok, 2'b01);

        // R2 parity
        blk_mode = 1'b0; copy_sel = 2'b11;
        phase(0, 16'd6, 1'b0, 1'b1);
        chk("R2 bad address parity flagged", par_err, 1'b1);
        do_wr(ma[6], 1'b0);
        do_wr(16'h9999, 1'b0);
        do_addr(6, 1'b0, 2'b11);
        chk("R2 par_err cleared", par_err, 1'b0);
        do_rd("R2 idle writes ignored", 1'b0, ma[6]);
        do_addr(6, 1'b0, 2'b11);
        do_wr(ma[6], 1'b0);
        phase(1, 16'h7777, 1'b0, 1'b1);
        chk("R2 bad data parity flagged", par_err, 1'b1);
        do_wr(16'h6666, 1'b0);
        do_addr(6, 1'b0, 2'b11);
        do_rd("R2 bad phase ignored", 1'b0, 16'h6666);

        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule